// File: doc/BRIEF.md
# SPI Slave Chip-Select Watcher

This block sits beside the receive shifter of an SPI slave. It watches the slave's active-low chip-select line and owns the shifter's bit counter. The raw chip-select input passes through a synchroniser made of flip-flops. Edges are detected on the synchronised level. When continuous mode and the edge-interrupt enable are both set, each edge latches its own sticky flag. Assertion is a high-to-low edge and deassertion is a low-to-high edge. Any set flag drives the interrupt line.

The block also detects chip-select being dropped partway through a word. That condition is a chip-select error, and a policy input decides what happens to the bit counter afterwards. With the policy set, the counter returns to zero and software is expected to disable the block. With it clear, the counter keeps its position, so the remaining bits of the word complete once chip-select is asserted again. All sticky flags clear on a status-read strobe. Data shifting and buffering belong to neighbouring logic. Every pin here is plain control or status, so no interface needs back-pressure rules.

Top module: `spi_cs_watch`

## Requirements
- R1: `cs_n_raw` passes through SYNC_STAGES flip-flops (default 2). A change on it can set a flag or affect the counter no earlier than SYNC_STAGES+1 rising clock edges after it is applied. With the default that is the third edge, and after two edges no flag has yet changed.
- R2: When `cont_mode`, `cs_irq_en` and `spi_en` are all 1, an assertion edge (1 to 0) sets `cs_fall_flg` and a deassertion edge (0 to 1) sets `cs_rise_flg`. `irq` is 1 whenever any of the three flags is 1.
- R3: If `cont_mode` is 0 or `cs_irq_en` is 0, chip-select edges set neither edge flag and raise no `irq`.
- R4: While `spi_en` is 1 and the synchronised chip-select is low, each `sclk_smp` pulse increments `bit_cnt` from 0 up to BITS_PER_WORD-1 (default 7), then wraps it to 0. `byte_done` is 1 for the single cycle after the wrapping edge. Pulses are ignored while chip-select is high. `spi_en` = 0 forces `bit_cnt` to 0.
- R5: A deassertion edge seen while `spi_en` = 1 and `bit_cnt` is not 0 sets `cs_err_flg`, whatever the state of `cont_mode` and `cs_irq_en`. A deassertion edge seen while `bit_cnt` = 0 does not set it.
- R6: When `cnt_restart` = 1, a chip-select error returns `bit_cnt` to 0 on the same edge that sets `cs_err_flg`.
- R7: When `cnt_restart` = 0, a chip-select error leaves `bit_cnt` unchanged. After chip-select is asserted again, the remaining pulses complete the word and `byte_done` fires.
- R8: A one-cycle `stat_rd` pulse clears all three flags on the next rising edge. If a new event arrives on that same edge, the event's flag is set.
- R9: After reset, all flags, `irq`, `byte_done` and `bit_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_raw | input | 1 | Unsynchronised active-low chip-select |
| sclk_smp | input | 1 | One-cycle pulse per serial clock sampling edge, in the clk domain |
| spi_en | input | 1 | Block enable; 0 holds the counter at zero |
| cont_mode | input | 1 | Continuous-mode select |
| cs_irq_en | input | 1 | Enable for the chip-select edge flags |
| cnt_restart | input | 1 | Error policy: 1 = counter to zero, 0 = counter holds |
| stat_rd | input | 1 | Status-read strobe that clears the flags |
| bit_cnt | output | CNT_W (3) | Current bit position within the word |
| byte_done | output | 1 | Pulse after a word completes |
| cs_rise_flg | output | 1 | Sticky flag for a deassertion edge |
| cs_fall_flg | output | 1 | Sticky flag for an assertion edge |
| cs_err_flg | output | 1 | Sticky flag for a chip-select error |
| irq | output | 1 | Interrupt, the OR of the flags |

## Verification
A `sclk_smp` pulse updates `bit_cnt` and `byte_done` on the same rising edge that samples it. A chip-select change applied at a falling edge reaches the flags and the counter on the third following rising edge. The R1 check looks after the second edge to confirm that nothing has moved yet. A `stat_rd` pulse takes effect on the edge that samples it. The bench drives every input at a falling edge, steps whole cycles, and compares expectations at the next falling edge, once all of these latencies have elapsed. For the R8 collision case, the read is timed so that it lands exactly on the edge where the edge pulse sets the flag.

// File: rtl/spi_csw_pkg.sv
package spi_csw_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic err;
  } csw_evt_t;
endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_raw,
  output logic cs_n_s,
  output logic rise_p,
  output logic fall_p
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= cs_n_raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain[STAGES-1];

  assign cs_n_s = chain[STAGES-1];
  assign rise_p = cs_n_s & ~prev_q;
  assign fall_p = ~cs_n_s & prev_q;
endmodule

// File: rtl/csw_bitcnt.sv
module csw_bitcnt #(
  parameter int BITS  = 8,
  parameter int CNT_W = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cs_act,
  input  logic             smp,
  input  logic             err_evt,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);
  logic step;
  assign step = smp & cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= en & step & (cnt == LAST);
      if (!en)                    cnt <= '0;
      else if (err_evt & restart) cnt <= '0;
      else if (step)              cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/csw_flags.sv
module csw_flags
  import spi_csw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  csw_evt_t evt,
  input  logic     rd,
  output csw_evt_t flags
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= evt | (flags & {3{~rd}});
endmodule

// File: rtl/spi_cs_watch.sv
module spi_cs_watch
  import spi_csw_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BITS_PER_WORD = 8,
  localparam int CNT_W        = $clog2(BITS_PER_WORD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_raw,
  input  logic             sclk_smp,
  input  logic             spi_en,
  input  logic             cont_mode,
  input  logic             cs_irq_en,
  input  logic             cnt_restart,
  input  logic             stat_rd,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             byte_done,
  output logic             cs_rise_flg,
  output logic             cs_fall_flg,
  output logic             cs_err_flg,
  output logic             irq
);
  logic     cs_n_s, rise_p, fall_p, edge_ok, err_evt;
  csw_evt_t evt, flags;

  csw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n_raw),
    .cs_n_s(cs_n_s), .rise_p(rise_p), .fall_p(fall_p)
  );

  assign err_evt = rise_p & spi_en & (bit_cnt != '0);
  assign edge_ok = spi_en & cont_mode & cs_irq_en;
  assign evt     = '{rise: rise_p & edge_ok, fall: fall_p & edge_ok, err: err_evt};

  csw_bitcnt #(.BITS(BITS_PER_WORD), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(spi_en), .cs_act(~cs_n_s), .smp(sclk_smp),
    .err_evt(err_evt), .restart(cnt_restart), .cnt(bit_cnt), .done(byte_done)
  );

  csw_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd(stat_rd), .flags(flags)
  );

  assign cs_rise_flg = flags.rise;
  assign cs_fall_flg = flags.fall;
  assign cs_err_flg  = flags.err;
  assign irq         = |flags;
endmodule

// File: rtl/spi_cs_watch_chk.sv
module spi_cs_watch_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cont_mode,
  input logic             cs_irq_en,
  input logic             cnt_restart,
  input logic             spi_en,
  input logic             stat_rd,
  input logic             err_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cs_rise_flg,
  input logic             cs_fall_flg,
  input logic             cs_err_flg
);
  AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_rise_flg) || $rose(cs_fall_flg)) |-> $past(cont_mode && cs_irq_en)); // R3

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && cnt_restart) |=> (bit_cnt == '0)); // R6

  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !cnt_restart) |=> ((bit_cnt == $past(bit_cnt)) || !spi_en)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !err_evt) |=> !cs_err_flg); // R8
endmodule

bind spi_cs_watch spi_cs_watch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode), .cs_irq_en(cs_irq_en),
  .cnt_restart(cnt_restart), .spi_en(spi_en), .stat_rd(stat_rd),
  .err_evt(err_evt), .bit_cnt(bit_cnt), .cs_rise_flg(cs_rise_flg),
  .cs_fall_flg(cs_fall_flg), .cs_err_flg(cs_err_flg)
);

// File: tb/tb_spi_cs_watch.sv
module tb_spi_cs_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_raw = 1'b1, sclk_smp = 1'b0, spi_en = 1'b1, cont_mode = 1'b1;
  logic cs_irq_en = 1'b1, cnt_restart = 1'b1, stat_rd = 1'b0;
  logic [2:0] bit_cnt;
  logic byte_done, cs_rise_flg, cs_fall_flg, cs_err_flg, irq;

  always #10 clk = ~clk;

  spi_cs_watch dut (
    .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n_raw), .sclk_smp(sclk_smp),
    .spi_en(spi_en), .cont_mode(cont_mode), .cs_irq_en(cs_irq_en),
    .cnt_restart(cnt_restart), .stat_rd(stat_rd), .bit_cnt(bit_cnt),
    .byte_done(byte_done), .cs_rise_flg(cs_rise_flg), .cs_fall_flg(cs_fall_flg),
    .cs_err_flg(cs_err_flg), .irq(irq)
  );

  typedef struct {
    string req;
    int rise, fall, err, irq, cnt, done;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0, n_bad = 0;
  event chk_ev;
  bit   finished = 0;

  task automatic cmp(string req, string what, int act, int expv);
    if (expv >= 0) begin
      n_vec++;
      if (act != expv) begin
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
    end
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.req, "rise", int'(cs_rise_flg), e.rise);
        cmp(e.req, "fall", int'(cs_fall_flg), e.fall);
        cmp(e.req, "err",  int'(cs_err_flg),  e.err);
        cmp(e.req, "irq",  int'(irq),         e.irq);
        cmp(e.req, "cnt",  int'(bit_cnt),     e.cnt);
        cmp(e.req, "done", int'(byte_done),   e.done);
      end
    end
  end

  task automatic expect_now(string req, int r, int f, int e, int q, int c, int d);
    exp_t x;
    x = '{req: req, rise: r, fall: f, err: e, irq: q, cnt: c, done: d};
    exp_q.push_back(x);
    ->chk_ev;
    #1;
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      sclk_smp = 1'b1;
      step();
      sclk_smp = 1'b0;
      if (i != n - 1) step();
    end
  endtask

  task automatic rd();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    step(3);
    rst_n = 1'b1;
    step();
    expect_now("R9", 0, 0, 0, 0, 0, 0);

    cs_n_raw = 1'b0;
    step(2);
    expect_now("R1", 0, 0, 0, 0, 0, -1);
    step();
    expect_now("R2", 0, 1, 0, 1, 0, -1);
    rd();
    expect_now("R8", 0, 0, 0, 0, -1, -1);

    pulses(3);
    expect_now("R4", -1, -1, -1, -1, 3, 0);
    step();
    pulses(5);
    expect_now("R4", -1, -1, -1, -1, 0, 1);
    step();

    pulses(3);
    step();
    cs_n_raw = 1'b1;
    step(3);
    expect_now("R5_R6", 1, 0, 1, 1, 0, -1);
    rd();
    cs_n_raw = 1'b0;
    step(3);
    rd();

    cnt_restart = 1'b0;
    pulses(5);
    step();
    cs_n_raw = 1'b1;
    step(3);
    expect_now("R7", 1, 0, 1, 1, 5, -1);
    pulses(2);
    step();
    expect_now("R4", -1, -1, -1, -1, 5, 0);
    rd();
    cs_n_raw = 1'b0;
    step(3);
    pulses(2);
    expect_now("R7", -1, -1, -1, -1, 7, 0);
    step();
    pulses(1);
    expect_now("R7", -1, -1, -1, -1, 0, 1);
    step();
    rd();

    cs_n_raw = 1'b1;
    step(3);
    expect_now("R5", 1, 0, 0, 1, 0, -1);
    rd();

    cont_mode = 1'b0;
    cs_n_raw = 1'b0;
    step(3);
    expect_now("R3", 0, 0, 0, 0, -1, -1);
    cont_mode = 1'b1;
    cs_irq_en = 1'b0;
    cs_n_raw = 1'b1;
    step(3);
    expect_now("R3", 0, 0, 0, 0, -1, -1);
    cs_irq_en = 1'b1;

    cs_n_raw = 1'b0;
    step(2);
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    expect_now("R8", 0, 1, 0, 1, -1, -1);
    rd();

    pulses(3);
    expect_now("R4", -1, -1, -1, -1, 3, -1);
    step();
    spi_en = 1'b0;
    step();
    expect_now("R4", -1, -1, -1, -1, 0, -1);
    pulses(2);
    step();
    expect_now("R4", -1, -1, -1, -1, 0, 0);

    step(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule